// File: doc/BRIEF.md
# Bus clock and reset sequencer

This block produces the bus clock enables for the CPU and the peripherals of a small microcontroller subsystem. It works entirely in the system clock domain. The oscillator and the PLL arrive as single-cycle tick strobes. A select bit picks which of the two strobes feeds a chain of two divide-by-two stages. Every fourth tick of the chosen source yields one bus cycle. The outputs are one-cycle enable pulses, not gated clocks.

A power-on or low-voltage request holds all bus enables idle and pulls the active-low reset pin down. This lasts until 4096 oscillator ticks have been counted after the request drops. A new request during that window restarts the count. While the bus runs, a wait request stops the CPU enable and leaves the peripheral enable toggling. A wake input brings the CPU enable back at the next bus cycle.

Top module: `bus_clk_seq`

## Requirements
- R1: While rst_ni is low, rst_pin_no, per_clk_en_o and cpu_clk_en_o are all 0.
- R2: A cycle in which por_req_i or lvi_req_i is high makes rst_pin_no 0 from the next cycle. rst_pin_no returns to 1 the cycle after the 4096th osc_tick_i counted in cycles with no request, and the count starts at the first such cycle. The same stretch follows release of rst_ni.
- R3: A request arriving while the stretch is in progress restarts the 4096-tick count from zero.
- R4: per_clk_en_o and cpu_clk_en_o stay 0 in every cycle in which rst_pin_no is 0 in both that cycle and the previous one.
- R5: Once rst_pin_no is 1, the selected source ticks are counted from zero. The cycle after every fourth tick, per_clk_en_o pulses high for one cycle.
- R6: A select value of 1 chooses pll_tick_i and 0 chooses osc_tick_i. src_sel_i is taken while the pin is low, and after that only on the cycle of a fourth tick. A change at any other time waits for that boundary.
- R7: A wait_req_i sampled high while running sets wait mode from the next cycle. A per_clk_en_o pulse produced from a cycle in wait mode has no cpu_clk_en_o pulse with it. Otherwise cpu_clk_en_o equals per_clk_en_o.
- R8: wake_i sampled high clears wait mode from the next cycle and wins over a simultaneous wait_req_i. The CPU enable resumes with the next per_clk_en_o pulse.
- R9: cpu_clk_en_o is never 1 unless per_clk_en_o is 1 in the same cycle.
- R10: A power-on or low-voltage request cancels wait mode, so the CPU enable runs after the pin rises.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| osc_tick_i | input | 1 | Oscillator tick strobe |
| pll_tick_i | input | 1 | PLL tick strobe |
| src_sel_i | input | 1 | Source select, 1 = PLL, 0 = oscillator |
| por_req_i | input | 1 | Power-on reset request |
| lvi_req_i | input | 1 | Low-voltage reset request |
| wait_req_i | input | 1 | Enter wait mode |
| wake_i | input | 1 | Leave wait mode |
| rst_pin_no | output | 1 | Active-low reset pin drive |
| cpu_clk_en_o | output | 1 | CPU bus clock enable pulse |
| per_clk_en_o | output | 1 | Peripheral bus clock enable pulse |

## Verification
The bench checks the exact release cycle of the reset pin, with both sparse and dense oscillator ticks. An off-by-one count would release the pin a tick early or late. It retriggers the stretch midway with the other request type. A design that failed to restart the count would release thousands of cycles too soon. Select changes are made between boundaries and during reset. A design that switched sources at once would shorten a bus cycle and emit an early pulse. The bench also issues wake together with a wait request, and a reset request while in wait mode. A wrong priority, or a stale wait flag, would silence the CPU enable when it should run.

// File: rtl/bcs_pkg.sv
package bcs_pkg;
  localparam int unsigned BCS_TIMEOUT_DEF = 4096;
  localparam int unsigned BCS_DIV_STAGES_DEF = 2;
endpackage

// File: rtl/bcs_rst_stretch.sv
module bcs_rst_stretch #(
  parameter int unsigned TIMEOUT = bcs_pkg::BCS_TIMEOUT_DEF
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic osc_tick_i,
  input  logic req_i,
  output logic busy_o
);
  localparam int unsigned CNT_W = $clog2(TIMEOUT);
  localparam logic [CNT_W-1:0] LAST = CNT_W'(TIMEOUT - 1);

  logic [CNT_W-1:0] cnt_q;
  logic             busy_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q  <= '0;
      busy_q <= 1'b1;
    end else if (req_i) begin
      cnt_q  <= '0;
      busy_q <= 1'b1;
    end else if (busy_q && osc_tick_i) begin
      if (cnt_q == LAST) begin
        busy_q <= 1'b0;
        cnt_q  <= '0;
      end else begin
        cnt_q <= cnt_q + 1'b1;
      end
    end
  end

  assign busy_o = busy_q;

  AST_REQ_RESTART: assert property (@(posedge clk_i) disable iff (!rst_ni)
    req_i |=> (busy_q && cnt_q == '0)); // R3
  AST_RELEASE_LAST: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (busy_q && !req_i && osc_tick_i && cnt_q == LAST) |=> !busy_q); // R2
  AST_HOLD_NO_TICK: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (busy_q && !req_i && !osc_tick_i) |=> (busy_q && $stable(cnt_q))); // R2
endmodule

// File: rtl/bcs_bus_div.sv
module bcs_bus_div #(
  parameter int unsigned STAGES = bcs_pkg::BCS_DIV_STAGES_DEF
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic run_i,
  input  logic osc_tick_i,
  input  logic pll_tick_i,
  input  logic sel_i,
  output logic bus_pulse_o
);
  logic              sel_q;
  logic              src_tick;
  logic [STAGES-1:0] stage_q;
  logic [STAGES-1:0] carry;
  logic              bound;

  assign src_tick = sel_q ? pll_tick_i : osc_tick_i;

  // cascaded divide-by-two stages
  for (genvar k = 0; k < STAGES; k++) begin : g_stg
    logic q;
    if (k == 0) begin : g_first
      assign carry[k] = src_tick;
    end else begin : g_next
      assign carry[k] = carry[k-1] & stage_q[k-1];
    end
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)       q <= 1'b0;
      else if (!run_i)   q <= 1'b0;
      else if (carry[k]) q <= ~q;
    end
    assign stage_q[k] = q;
  end

  assign bound       = carry[STAGES-1] & stage_q[STAGES-1];
  assign bus_pulse_o = run_i & bound;

  // select only moves at a bus boundary or while idle
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)               sel_q <= 1'b0;
    else if (!run_i || bound)  sel_q <= sel_i;
  end

  AST_SEL_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (run_i && !bound) |=> $stable(sel_q)); // R6
  AST_IDLE_CLEAR: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !run_i |=> (stage_q == '0)); // R5
endmodule

// File: rtl/bcs_wait_ctl.sv
module bcs_wait_ctl (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic run_i,
  input  logic wait_req_i,
  input  logic wake_i,
  input  logic bus_pulse_i,
  output logic cpu_en_o,
  output logic per_en_o
);
  logic wait_q;
  logic cpu_q;
  logic per_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)         wait_q <= 1'b0;
    else if (!run_i)     wait_q <= 1'b0;
    else if (wake_i)     wait_q <= 1'b0;
    else if (wait_req_i) wait_q <= 1'b1;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      per_q <= 1'b0;
      cpu_q <= 1'b0;
    end else begin
      per_q <= bus_pulse_i;
      cpu_q <= bus_pulse_i & ~wait_q;
    end
  end

  assign cpu_en_o = cpu_q;
  assign per_en_o = per_q;

  AST_WAKE_CLEARS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wake_i |=> !wait_q); // R8
  AST_CPU_SUBSET: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cpu_en_o |-> per_en_o); // R9
  AST_PER_SPACING: assert property (@(posedge clk_i) disable iff (!rst_ni)
    per_en_o |=> !per_en_o); // R5
  AST_WAIT_GATES: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wait_q && !wake_i && run_i) |=> !cpu_en_o); // R7
endmodule

// File: rtl/bus_clk_seq.sv
module bus_clk_seq #(
  parameter int unsigned TIMEOUT    = bcs_pkg::BCS_TIMEOUT_DEF,
  parameter int unsigned DIV_STAGES = bcs_pkg::BCS_DIV_STAGES_DEF
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic osc_tick_i,
  input  logic pll_tick_i,
  input  logic src_sel_i,
  input  logic por_req_i,
  input  logic lvi_req_i,
  input  logic wait_req_i,
  input  logic wake_i,
  output logic rst_pin_no,
  output logic cpu_clk_en_o,
  output logic per_clk_en_o
);
  logic busy;
  logic run;
  logic bus_pulse;

  bcs_rst_stretch #(.TIMEOUT(TIMEOUT)) u_stretch (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .osc_tick_i (osc_tick_i),
    .req_i      (por_req_i | lvi_req_i),
    .busy_o     (busy)
  );

  assign run        = ~busy;
  assign rst_pin_no = ~busy;

  bcs_bus_div #(.STAGES(DIV_STAGES)) u_div (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .run_i       (run),
    .osc_tick_i  (osc_tick_i),
    .pll_tick_i  (pll_tick_i),
    .sel_i       (src_sel_i),
    .bus_pulse_o (bus_pulse)
  );

  bcs_wait_ctl u_wait (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .run_i       (run),
    .wait_req_i  (wait_req_i),
    .wake_i      (wake_i),
    .bus_pulse_i (bus_pulse),
    .cpu_en_o    (cpu_clk_en_o),
    .per_en_o    (per_clk_en_o)
  );

  AST_PIN_QUIET: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!rst_pin_no && $past(!rst_pin_no)) |-> (!per_clk_en_o && !cpu_clk_en_o)); // R4
  AST_REQ_PIN_LOW: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (por_req_i || lvi_req_i) |=> !rst_pin_no); // R2
endmodule

// File: tb/tb_bus_clk_seq.sv
module tb_bus_clk_seq;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic osc = 1'b0, pll = 1'b0, sel = 1'b0;
  logic por = 1'b0, lvi = 1'b0, wreq = 1'b0, wake = 1'b0;
  logic pin, cpu_en, per_en;

  int n_cmp = 0, n_bad = 0;
  string phase = "R1";
  logic prev_pin = 1'b0;

  always #2 clk = ~clk;

  bus_clk_seq dut (
    .clk_i(clk), .rst_ni(rst_n), .osc_tick_i(osc), .pll_tick_i(pll),
    .src_sel_i(sel), .por_req_i(por), .lvi_req_i(lvi), .wait_req_i(wreq),
    .wake_i(wake), .rst_pin_no(pin), .cpu_clk_en_o(cpu_en), .per_clk_en_o(per_en)
  );

  // reference model built from the requirements
  logic m_busy, m_sel, m_wait, m_per, m_cpu;
  int   m_cnt, m_stg;

  function automatic logic model_pulse(logic busy, logic s, int stg, logic o, logic p);
    logic t;
    t = s ? p : o;
    return !busy && t && (stg == 3);
  endfunction

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_busy <= 1'b1; m_cnt <= 0; m_stg <= 0; m_sel <= 1'b0;
      m_wait <= 1'b0; m_per <= 1'b0; m_cpu <= 1'b0;
    end else begin
      logic pulse, tick;
      tick  = m_sel ? pll : osc;
      pulse = model_pulse(m_busy, m_sel, m_stg, osc, pll);
      m_per <= pulse;
      m_cpu <= pulse && !m_wait;
      if (m_busy) m_stg <= 0;
      else if (tick) m_stg <= (m_stg + 1) % 4;
      if (m_busy || (tick && m_stg == 3)) m_sel <= sel;
      if (m_busy) m_wait <= 1'b0;
      else if (wake) m_wait <= 1'b0;
      else if (wreq) m_wait <= 1'b1;
      if (por || lvi) begin
        m_busy <= 1'b1; m_cnt <= 0;
      end else if (m_busy && osc) begin
        if (m_cnt == 4095) begin m_busy <= 1'b0; m_cnt <= 0; end
        else m_cnt <= m_cnt + 1;
      end
    end
  end

  task automatic chk(string req, string what, logic act, logic exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s (%s phase) %s: actual=%0b expected=%0b at %0t",
               req, phase, what, act, exp, $time);
    end
  endtask

  task automatic compare();
    chk("R2", "rst_pin_no", pin, !m_busy);
    chk("R5", "per_clk_en_o", per_en, m_per);
    chk("R7", "cpu_clk_en_o", cpu_en, m_cpu);
    if (cpu_en) chk("R9", "per with cpu", per_en, 1'b1);
    if (!pin && !prev_pin) chk("R4", "enables idle", per_en | cpu_en, 1'b0);
    prev_pin = pin;
  endtask

  task automatic drive(int osc_pct, int pll_pct, int sel_pct,
                       int w_pct, int wk_pct, int req_pct);
    osc  = ($urandom % 100) < osc_pct;
    pll  = ($urandom % 100) < pll_pct;
    if (($urandom % 100) < sel_pct) sel = ~sel;
    wreq = ($urandom % 100) < w_pct;
    wake = ($urandom % 100) < wk_pct;
    por  = ($urandom % 1000) < req_pct;
    lvi  = 1'b0;
  endtask

  task automatic cyc(int n, int osc_pct, int pll_pct, int sel_pct,
                     int w_pct, int wk_pct, int req_pct);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      compare();
      drive(osc_pct, pll_pct, sel_pct, w_pct, wk_pct, req_pct);
    end
  endtask

  task automatic hold(int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      compare();
    end
  endtask

  task automatic summary();
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_bad++;
    $display("FAIL watchdog: actual=hung expected=finished");
    summary();
    $finish;
  end

  initial begin
    void'($urandom(32'h5eed_0bc5));
    // R1: reset state
    repeat (3) @(negedge clk);
    chk("R1", "pin in reset", pin, 1'b0);
    chk("R1", "per in reset", per_en, 1'b0);
    chk("R1", "cpu in reset", cpu_en, 1'b0);
    rst_n = 1'b1;
    // R2: stretch after reset, dense oscillator
    phase = "R2";
    cyc(4200, 100, 50, 3, 2, 3, 0);
    chk("R2", "pin released", pin, 1'b1);
    // R5: random running
    phase = "R5";
    cyc(3000, 50, 60, 2, 2, 3, 0);
    // R3: retrigger mid-stretch with other request type
    phase = "R3";
    @(negedge clk); compare(); por = 1'b1;
    @(negedge clk); compare(); por = 1'b0; osc = 1'b1;
    hold(2000);
    lvi = 1'b1;
    @(negedge clk); compare(); lvi = 1'b0;
    hold(3000);
    chk("R3", "pin still low after restart", pin, 1'b0);
    hold(1200);
    chk("R3", "pin released after restart", pin, 1'b1);
    // R6: PLL path then oscillator path, flips mid-cycle
    phase = "R6";
    sel = 1'b1; pll = 1'b1; osc = 1'b0; wreq = 1'b0; wake = 1'b0;
    hold(200);
    sel = 1'b0; osc = 1'b1; pll = 1'b0;
    hold(3);
    sel = 1'b1;
    hold(2);
    sel = 1'b0;
    hold(200);
    cyc(1500, 40, 70, 10, 0, 0, 0);
    // R8: wait, then wake with simultaneous wait request
    phase = "R8";
    sel = 1'b0; osc = 1'b1; pll = 1'b0;
    @(negedge clk); compare(); wreq = 1'b1;
    @(negedge clk); compare(); wreq = 1'b0;
    hold(40);
    wreq = 1'b1; wake = 1'b1;
    @(negedge clk); compare(); wreq = 1'b0; wake = 1'b0;
    hold(40);
    cyc(1500, 60, 60, 1, 5, 5, 0);
    // R10: request while in wait mode
    phase = "R10";
    sel = 1'b0; osc = 1'b1; wake = 1'b0;
    @(negedge clk); compare(); wreq = 1'b1;
    @(negedge clk); compare(); wreq = 1'b0;
    hold(10);
    lvi = 1'b1;
    @(negedge clk); compare(); lvi = 1'b0;
    hold(4120);
    chk("R10", "pin released", pin, 1'b1);
    cyc(3000, 70, 30, 2, 1, 2, 1);
    summary();
    $finish;
  end
endmodule